// File: doc/BRIEF.md
# RGB Channel Sequencer with Mode Control

This block decides, on every rising edge of the ADC sample clock, which of three colour inputs (red, green, blue) a shared converter works on next. A small state machine holds the current colour. Three sources can drive it, in fixed priority. An active-low external override takes the colour from two select pins. A single-channel mode takes it from a two-bit configuration pointer. Otherwise the block rotates automatically, one colour per sample clock. An active-low line-start input restarts the rotation at red.

The current colour selects the matching gain and offset values from the register file and drives a one-hot channel-valid vector. The colour index also travels through a four-stage tag pipeline that matches the converter latency, so each converted word leaves with the colour it was sampled from. A separate test selector routes one colour path to a test output when its active-low enable is asserted. A reserved select code (11) on the active source leaves the colour unchanged and sets a sticky error flag.

The state machine has three states: ST_RED (code 00), ST_GREEN (01) and ST_BLUE (10). It has five named transitions:
- FORCE loads the external-pin colour.
- POINT loads the configuration-pointer colour.
- RESTART goes to ST_RED.
- ROTATE steps ST_RED to ST_GREEN to ST_BLUE and back to ST_RED.
- HOLD keeps the state on a reserved code.

Top module: `rgb_seq`

## Requirements
- R1: While `rst_n` is low, `color_idx` is 00 (red), `chan_valid` is 001, `sel_err` is 0 and `tag_valid` is 0.
- R2: With `ext_sel_n` high, `single_mode` low and `line_start_n` high, each rising edge advances the colour from red (00) to green (01) to blue (10) and back to red. `chan_valid` is one-hot, with bit 0 for red, bit 1 for green and bit 2 for blue.
- R3: In rotation mode, `line_start_n` low makes the colour red on the next edge. Rotation resumes with green after it goes high.
- R4: With `ext_sel_n` high and `single_mode` high, each edge loads the colour from `cfg_color` (00 red, 01 green, 10 blue).
- R5: With `ext_sel_n` low, each edge loads the colour from `ext_color`, using the same encoding. This source takes priority over both `single_mode` and `line_start_n`.
- R6: Code 11 on the active source (`ext_color` or `cfg_color`) leaves the colour unchanged and sets `sel_err` on that edge.
- R7: `sel_err` stays high until reset, whatever happens to the inputs afterwards.
- R8: `cur_gain` and `cur_offset` always equal the gain and offset inputs of the colour shown on `color_idx`.
- R9: After edge k following reset, `tag_out` equals the `color_idx` value that held after edge k-4. `tag_valid` first goes high after the fourth edge following reset.
- R10: With `test_n` low, `test_route` is one-hot for the colour on `test_sel` (bit 0 red, bit 1 green, bit 2 blue). It is 000 for code 11 and whenever `test_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start_n | input | 1 | Line start, active low; restarts rotation at red |
| single_mode | input | 1 | 1 selects single-channel mode |
| cfg_color | input | 2 | Single-channel colour pointer |
| ext_sel_n | input | 1 | External colour override, active low |
| ext_color | input | 2 | External colour select pins |
| test_n | input | 1 | Test routing enable, active low |
| test_sel | input | 2 | Colour routed to the test output |
| gain_r | input | 5 | Red gain register |
| gain_g | input | 5 | Green gain register |
| gain_b | input | 5 | Blue gain register |
| offset_r | input | 8 | Red offset register |
| offset_g | input | 8 | Green offset register |
| offset_b | input | 8 | Blue offset register |
| color_idx | output | 2 | Current colour index |
| chan_valid | output | 3 | One-hot current channel |
| cur_gain | output | 5 | Gain of current colour |
| cur_offset | output | 8 | Offset of current colour |
| tag_out | output | 2 | Colour tag aligned with converter output |
| tag_valid | output | 1 | Tag pipeline filled since reset |
| sel_err | output | 1 | Sticky reserved-code flag |
| test_route | output | 3 | One-hot test path select |

## Verification
The hardest situation to reach is a change of selection source while the rotation sits at a chosen phase. Examples are the external override firing while line-start is low, and rotation resuming from a colour that the override left behind. The stimulus table reaches these by stepping the sources edge by edge: it rotates, restarts, points, forces, then hands control back to rotation. The error flag is kept clear until late in the table so that its first rise can be seen. A separate reset exercises a reserved pointer code from a clean state, and the tag check keeps a history of expected colours to verify the four-edge delay across all of these source changes.

// File: rtl/rgb_seq_pkg.sv
package rgb_seq_pkg;

    localparam int COLOR_W    = 2;
    localparam int NUM_COLORS = 3;

    typedef enum logic [COLOR_W-1:0] {
        ST_RED   = 2'b00,
        ST_GREEN = 2'b01,
        ST_BLUE  = 2'b10
    } color_e;

    typedef enum logic [1:0] {
        SRC_EXT,
        SRC_PTR,
        SRC_LINE,
        SRC_ROT
    } src_e;

    localparam logic [COLOR_W-1:0] CODE_RSVD = 2'b11;

endpackage

// File: rtl/rgb_seq_fsm.sv
module rgb_seq_fsm
    import rgb_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start_n,
    input  logic               single_mode,
    input  logic [COLOR_W-1:0] cfg_color,
    input  logic               ext_sel_n,
    input  logic [COLOR_W-1:0] ext_color,
    output color_e             state_o,
    output logic               sel_err_o
);

    color_e             state_q;
    color_e             state_d;
    src_e               src;
    logic [COLOR_W-1:0] code;
    logic               rsvd_hit;
    logic               sel_err_q;

    // Source priority: external pins, then pointer, then line restart, then rotation
    always_comb begin
        if (!ext_sel_n)         src = SRC_EXT;
        else if (single_mode)   src = SRC_PTR;
        else if (!line_start_n) src = SRC_LINE;
        else                    src = SRC_ROT;
    end

    always_comb begin
        state_d  = state_q;
        rsvd_hit = 1'b0;
        code     = (src == SRC_EXT) ? ext_color : cfg_color;
        unique case (src)
            SRC_EXT, SRC_PTR: begin
                if (code == CODE_RSVD) begin
                    rsvd_hit = 1'b1;              // HOLD
                end else begin
                    state_d = color_e'(code);     // FORCE / POINT
                end
            end
            SRC_LINE: state_d = ST_RED;           // RESTART
            SRC_ROT: begin                        // ROTATE
                unique case (state_q)
                    ST_RED:   state_d = ST_GREEN;
                    ST_GREEN: state_d = ST_BLUE;
                    ST_BLUE:  state_d = ST_RED;
                    default:  state_d = ST_RED;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RED;
        else        state_q <= state_d;
    end

    // Output register: sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sel_err_q <= 1'b0;
        else if (rsvd_hit) sel_err_q <= 1'b1;
    end

    assign state_o   = state_q;
    assign sel_err_o = sel_err_q;

    a_r3_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel_n && !single_mode && !line_start_n) |=> (state_q == ST_RED));

    a_r2_rotate_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel_n && !single_mode && line_start_n && state_q == ST_BLUE)
        |=> (state_q == ST_RED));

    a_r5_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel_n && ext_color != CODE_RSVD) |=> (state_q == $past(ext_color)));

    a_r6_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel_n && ext_color == CODE_RSVD) |=> ($stable(state_q) && sel_err_q));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err_q |=> sel_err_q);

endmodule

// File: rtl/rgb_seq_mux.sv
module rgb_seq_mux
    import rgb_seq_pkg::*;
#(
    parameter int GAIN_W = 5,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  color_e            color_i,
    input  logic [GAIN_W-1:0] gain_i   [NUM_COLORS],
    input  logic [OFS_W-1:0]  offset_i [NUM_COLORS],
    output logic [NUM_COLORS-1:0] valid_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic [OFS_W-1:0]  offset_o
);

    for (genvar i = 0; i < NUM_COLORS; i++) begin : g_valid
        assign valid_o[i] = (color_i == COLOR_W'(i));
    end

    always_comb begin
        gain_o   = '0;
        offset_o = '0;
        for (int i = 0; i < NUM_COLORS; i++) begin
            if (color_i == COLOR_W'(i)) begin
                gain_o   = gain_i[i];
                offset_o = offset_i[i];
            end
        end
    end

    a_r2_valid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_o) == 1);

endmodule

// File: rtl/rgb_seq_tagpipe.sv
module rgb_seq_tagpipe #(
    parameter int W     = 2,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tag_i,
    output logic [W-1:0] tag_o,
    output logic         valid_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [W-1:0]     stg_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[i] <= '0;
                    vld_q[i] <= 1'b0;
                end else begin
                    stg_q[i] <= tag_i;
                    vld_q[i] <= 1'b1;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[i] <= '0;
                    vld_q[i] <= 1'b0;
                end else begin
                    stg_q[i] <= stg_q[i-1];
                    vld_q[i] <= vld_q[i-1];
                end
            end
        end
    end

    assign tag_o   = stg_q[DEPTH-1];
    assign valid_o = vld_q[DEPTH-1];

    // Checker-side edge counter since reset, saturating at DEPTH
    logic [CNT_W-1:0] edges_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 edges_q <= '0;
        else if (edges_q < DEPTH_C) edges_q <= edges_q + 1'b1;
    end

    a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (edges_q >= DEPTH_C));

endmodule

// File: rtl/rgb_seq_testsel.sv
module rgb_seq_testsel
    import rgb_seq_pkg::*;
(
    input  logic                  test_n,
    input  logic [COLOR_W-1:0]    test_sel,
    output logic [NUM_COLORS-1:0] route_o
);

    for (genvar i = 0; i < NUM_COLORS; i++) begin : g_route
        assign route_o[i] = !test_n && (test_sel == COLOR_W'(i));
    end

    always_comb begin
        a_r10_route_onehot0: assert ($onehot0(route_o));
    end

endmodule

// File: rtl/rgb_seq.sv
module rgb_seq
    import rgb_seq_pkg::*;
#(
    parameter int GAIN_W    = 5,
    parameter int OFS_W     = 8,
    parameter int TAG_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start_n,
    input  logic                  single_mode,
    input  logic [1:0]            cfg_color,
    input  logic                  ext_sel_n,
    input  logic [1:0]            ext_color,
    input  logic                  test_n,
    input  logic [1:0]            test_sel,
    input  logic [GAIN_W-1:0]     gain_r,
    input  logic [GAIN_W-1:0]     gain_g,
    input  logic [GAIN_W-1:0]     gain_b,
    input  logic [OFS_W-1:0]      offset_r,
    input  logic [OFS_W-1:0]      offset_g,
    input  logic [OFS_W-1:0]      offset_b,
    output logic [1:0]            color_idx,
    output logic [2:0]            chan_valid,
    output logic [GAIN_W-1:0]     cur_gain,
    output logic [OFS_W-1:0]      cur_offset,
    output logic [1:0]            tag_out,
    output logic                  tag_valid,
    output logic                  sel_err,
    output logic [2:0]            test_route
);

    color_e            color;
    logic [GAIN_W-1:0] gain_arr [NUM_COLORS];
    logic [OFS_W-1:0]  ofs_arr  [NUM_COLORS];

    assign gain_arr[0] = gain_r;
    assign gain_arr[1] = gain_g;
    assign gain_arr[2] = gain_b;
    assign ofs_arr[0]  = offset_r;
    assign ofs_arr[1]  = offset_g;
    assign ofs_arr[2]  = offset_b;

    rgb_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_n (line_start_n),
        .single_mode  (single_mode),
        .cfg_color    (cfg_color),
        .ext_sel_n    (ext_sel_n),
        .ext_color    (ext_color),
        .state_o      (color),
        .sel_err_o    (sel_err)
    );

    rgb_seq_mux #(
        .GAIN_W (GAIN_W),
        .OFS_W  (OFS_W)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .color_i  (color),
        .gain_i   (gain_arr),
        .offset_i (ofs_arr),
        .valid_o  (chan_valid),
        .gain_o   (cur_gain),
        .offset_o (cur_offset)
    );

    rgb_seq_tagpipe #(
        .W     (COLOR_W),
        .DEPTH (TAG_DEPTH)
    ) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_i   (color),
        .tag_o   (tag_out),
        .valid_o (tag_valid)
    );

    rgb_seq_testsel u_test (
        .test_n   (test_n),
        .test_sel (test_sel),
        .route_o  (test_route)
    );

    assign color_idx = color;

endmodule

// File: tb/test_rgb_seq.sv
module test_rgb_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;
    localparam logic [1:0] RED = 2'd0, GRN = 2'd1, BLU = 2'd2;

    // {ext_sel_n, ext_color[1:0], single_mode, cfg_color[1:0], line_start_n, exp_color[1:0], exp_err}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, GRN, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, BLU, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, RED, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, GRN, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, RED, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, RED, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, GRN, 1'b0},
        {1'b1, 2'd0, 1'b1, 2'd2, 1'b1, BLU, 1'b0},
        {1'b1, 2'd0, 1'b1, 2'd0, 1'b1, RED, 1'b0},
        {1'b1, 2'd0, 1'b1, 2'd1, 1'b1, GRN, 1'b0},
        {1'b0, 2'd2, 1'b1, 2'd0, 1'b1, BLU, 1'b0},
        {1'b0, 2'd0, 1'b1, 2'd1, 1'b1, RED, 1'b0},
        {1'b0, 2'd1, 1'b0, 2'd0, 1'b0, GRN, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, BLU, 1'b0},
        {1'b0, 2'd3, 1'b0, 2'd0, 1'b1, BLU, 1'b1},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, RED, 1'b1},
        {1'b1, 2'd0, 1'b1, 2'd3, 1'b1, RED, 1'b1},
        {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, RED, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n, line_start_n, single_mode, ext_sel_n, test_n;
    logic [1:0] cfg_color, ext_color, test_sel;
    logic [4:0] gain_r, gain_g, gain_b;
    logic [7:0] offset_r, offset_g, offset_b;
    logic [1:0] color_idx, tag_out;
    logic [2:0] chan_valid, test_route;
    logic [4:0] cur_gain;
    logic [7:0] cur_offset;
    logic       tag_valid, sel_err;

    int checks = 0;
    int errors = 0;
    logic [1:0] hist [NVEC+1];

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb_seq i_rgb_seq (
        .clk(clk), .rst_n(rst_n), .line_start_n(line_start_n),
        .single_mode(single_mode), .cfg_color(cfg_color),
        .ext_sel_n(ext_sel_n), .ext_color(ext_color),
        .test_n(test_n), .test_sel(test_sel),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .offset_r(offset_r), .offset_g(offset_g), .offset_b(offset_b),
        .color_idx(color_idx), .chan_valid(chan_valid),
        .cur_gain(cur_gain), .cur_offset(cur_offset),
        .tag_out(tag_out), .tag_valid(tag_valid),
        .sel_err(sel_err), .test_route(test_route)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string color_req(input int k);
        if (k < 4)  return "R2";
        if (k < 7)  return "R3";
        if (k < 10) return "R4";
        if (k < 13) return "R5";
        if (k == 13) return "R2";
        if (k < 17) return "R6";
        return "R3";
    endfunction

    function automatic int exp_gain(input logic [1:0] c);
        return (c == RED) ? 5 : (c == GRN) ? 17 : 30;
    endfunction

    function automatic int exp_ofs(input logic [1:0] c);
        return (c == RED) ? 8'h10 : (c == GRN) ? 8'h80 : 8'hF0;
    endfunction

    task automatic drive_idle();
        ext_sel_n = 1'b1; ext_color = 2'd0; single_mode = 1'b0;
        cfg_color = 2'd0; line_start_n = 1'b1; test_n = 1'b1; test_sel = 2'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive_idle();
        gain_r = 5'd5; gain_g = 5'd17; gain_b = 5'd30;
        offset_r = 8'h10; offset_g = 8'h80; offset_b = 8'hF0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 colour", color_idx, RED);
        chk("R1 chan_valid", chan_valid, 3'b001);
        chk("R1 sel_err", sel_err, 0);
        chk("R1 tag_valid", tag_valid, 0);

        @(negedge clk);
        rst_n = 1'b1;
        hist[0] = RED;
        for (int k = 0; k < NVEC; k++) begin
            logic [1:0] ec;
            ec = VEC[k][2:1];
            ext_sel_n    = VEC[k][9];
            ext_color    = VEC[k][8:7];
            single_mode  = VEC[k][6];
            cfg_color    = VEC[k][5:4];
            line_start_n = VEC[k][3];
            @(posedge clk);
            #1;
            hist[k+1] = ec;
            chk({color_req(k), " colour"}, color_idx, ec);
            chk({(k >= 15) ? "R7" : "R6", " sel_err"}, sel_err, VEC[k][0]);
            chk("R2 chan_valid", chan_valid, 3'b001 << ec);
            chk("R8 gain", cur_gain, exp_gain(ec));
            chk("R8 offset", cur_offset, exp_ofs(ec));
            if (k + 1 < 4) begin
                chk("R9 tag_valid low", tag_valid, 0);
            end else begin
                chk("R9 tag_valid high", tag_valid, 1);
                chk("R9 tag", tag_out, hist[k+1-4]);
            end
            @(negedge clk);
        end

        // Reset clears the sticky flag
        drive_idle();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 sel_err after reset", sel_err, 0);
        chk("R1 colour after reset", color_idx, RED);

        // Reserved pointer code from a clean state
        @(negedge clk);
        rst_n = 1'b1;
        single_mode = 1'b1;
        cfg_color = 2'd3;
        @(posedge clk);
        #1;
        chk("R6 reserved pointer hold", color_idx, RED);
        chk("R6 reserved pointer flag", sel_err, 1);

        // Test routing
        @(negedge clk);
        drive_idle();
        test_n = 1'b0; test_sel = 2'd1;
        #1;
        chk("R10 route green", test_route, 3'b010);
        test_sel = 2'd2;
        #1;
        chk("R10 route blue", test_route, 3'b100);
        test_sel = 2'd3;
        #1;
        chk("R10 route reserved", test_route, 3'b000);
        test_n = 1'b1; test_sel = 2'd0;
        #1;
        chk("R10 route disabled", test_route, 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule